// File: doc/BRIEF.md
# Suspend Clock-Stop Sequencer

This block orders the steps of a processor suspend and of the resume that follows it. Software first writes an 8-bit control byte. The byte holds a PLL settling delay in milliseconds and a bit that selects one of two suspend modes. A later write to the suspend command port, with its bit 0 set, starts a suspend. The sequencer drives the active-low suspend request to the core and waits for the core's active-low acknowledge.

In handshake-only mode the system clocks keep running. A break event releases the suspend request on the very next cycle. In clock-stop mode the sequencer raises a system clock-stop output once the acknowledge arrives. On a break event it lowers that output first. It then counts the programmed number of millisecond ticks so that the clock source and the core PLL can settle. Only after that does it release the suspend request. The sequence ends when the core withdraws its acknowledge.

Top module: `susp_seq_top`

## Requirements
- R1: The control register is 8 bits wide. Bits [7:4] hold the PLL delay in ms (0 to 15, one ms per count) and bit 0 enables clock-stop mode. Bits [3:1] are reserved: they are not stored and always read as 0 on `cfg_rd_data`.
- R2: After reset the control register reads 00h, `susp_req_n` is 1 and `clk_stop` is 0.
- R3: A command write with bit 0 = 1 while idle drives `susp_req_n` low after the next clock edge. A command write with bit 0 = 0 has no effect.
- R4: In handshake-only mode (enable bit 0), `clk_stop` stays 0 for the whole suspend. A break event after the acknowledge raises `susp_req_n` after the next edge.
- R5: In clock-stop mode, `clk_stop` stays 0 until `susp_ack_n` is seen low. It then rises after the next edge.
- R6: In clock-stop mode, a break event lowers `clk_stop` after the next edge, while `susp_req_n` stays low.
- R7: After `clk_stop` falls, `susp_req_n` stays low until N `ms_tick` pulses have been counted, where N is the programmed delay. It rises one cycle after the edge that takes the last tick. With N = 0 it rises the cycle after `clk_stop` falls. Ticks that arrive before `clk_stop` falls do not count.
- R8: A break event that arrives while the sequencer waits for the acknowledge is held. After the acknowledge the sequencer spends exactly one cycle suspended and then services the break.
- R9: Command writes during a suspend are ignored. The mode and delay are captured when the suspend starts, so control writes made during a suspend do not change it.
- R10: Once `susp_req_n` is released, the sequencer returns to idle when `susp_ack_n` goes high. A new command is accepted from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr_en | input | 1 | Control register write strobe |
| cfg_wr_data | input | 8 | Control register write data |
| cfg_rd_data | output | 8 | Control register read value |
| cmd_wr_en | input | 1 | Suspend command write strobe |
| cmd_wr_data | input | 8 | Suspend command data; bit 0 starts a suspend |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| brk_evt | input | 1 | Break/resume event pulse |
| susp_ack_n | input | 1 | Suspend acknowledge from the core, active low |
| susp_req_n | output | 1 | Suspend request to the core, active low |
| clk_stop | output | 1 | System clock-stop request, active high |

## Verification
The bench builds the block with its default parameters: a 4-bit delay field in an 8-bit register. This puts every delay value from 0 to 15 within reach, including the zero-delay edge case and the full-scale count. Seeded random scenarios vary the mode, the delay, the acknowledge latency, the spacing between ticks and the arrival time of the break. Ticks sent during the halted phase show that counting only starts after the clock-stop output drops. Writes made during a suspend show that they change neither the active suspend nor its timing.

// File: rtl/susp_pkg.sv
package susp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_REQ     = 3'd1,
    ST_HALT    = 3'd2,
    ST_SETTLE  = 3'd3,
    ST_RELEASE = 3'd4
  } susp_state_e;

  // Decrement that stops at zero.
  function automatic logic [7:0] dec_floor(input logic [7:0] v);
    return (v == 8'd0) ? 8'd0 : v - 8'd1;
  endfunction

  // Read value: delay field kept, reserved bits cleared, enable kept.
  function automatic logic [7:0] ctl_view(input logic [7:0] raw, input int dw);
    logic [7:0] r;
    r = 8'd0;
    for (int i = 0; i < 8; i++) begin
      if (i == 0 || i >= 8 - dw) r[i] = raw[i];
    end
    return r;
  endfunction

endpackage

// File: rtl/susp_ctl_reg.sv
module susp_ctl_reg #(
  parameter int REG_W = 8,
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic [DLY_W-1:0] dly_val,
  output logic             stop_en
);
  localparam int DLY_LSB = REG_W - DLY_W;
  localparam int RSV_W   = DLY_LSB - 1;

  logic [DLY_W-1:0] dly_q;
  logic             en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_q <= '0;
      en_q  <= 1'b0;
    end else if (wr_en) begin
      dly_q <= wr_data[REG_W-1:DLY_LSB];
      en_q  <= wr_data[0];
    end
  end

  generate
    if (RSV_W > 0) begin : g_rsv
      assign rd_data = {dly_q, {RSV_W{1'b0}}, en_q};
    end else begin : g_nrsv
      assign rd_data = {dly_q, en_q};
    end
  endgenerate

  assign dly_val = dly_q;
  assign stop_en = en_q;

  // R1: reserved bits always read as zero
  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[DLY_LSB-1:1] == '0);

  // R1: a write is reflected on the next cycle
  a_r1_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_data[0] == $past(wr_data[0])));

endmodule

// File: rtl/susp_delay_timer.sv
module susp_delay_timer #(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DLY_W-1:0] load_val,
  input  logic             tick,
  output logic             done
);
  import susp_pkg::*;

  logic [DLY_W-1:0] remain_q;
  logic [7:0]       remain_ext;

  assign remain_ext = 8'(remain_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain_q <= '0;
    end else if (load) begin
      remain_q <= load_val;
    end else if (tick) begin
      remain_q <= DLY_W'(dec_floor(remain_ext));
    end
  end

  assign done = (remain_q == '0);

  // R7: without a reload the count never grows
  a_r7_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(load) |-> remain_q <= $past(remain_q));

  // R7: count only moves on a tick or a load
  a_r7_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !tick) |=> $stable(remain_q));

endmodule

// File: rtl/susp_seq_fsm.sv
module susp_seq_fsm #(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_cmd,
  input  logic             stop_en,
  input  logic [DLY_W-1:0] dly_val,
  input  logic             brk_evt,
  input  logic             susp_ack_n,
  input  logic             timer_done,
  output logic             timer_load,
  output logic [DLY_W-1:0] timer_val,
  output logic             susp_req_n,
  output logic             clk_stop
);
  import susp_pkg::*;

  susp_state_e      state_q, state_d;
  logic             mode_q;
  logic [DLY_W-1:0] dly_q;
  logic             pend_q;

  // Named internal events
  logic ack_seen;
  logic brk_service;
  logic accept_cmd;
  logic settle_over;

  assign ack_seen    = !susp_ack_n;
  assign accept_cmd  = (state_q == ST_IDLE) && start_cmd;
  assign brk_service = (state_q == ST_HALT) && (brk_evt || pend_q);
  assign settle_over = (state_q == ST_SETTLE) && timer_done;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (accept_cmd) state_d = ST_REQ;
      ST_REQ:     if (ack_seen) state_d = ST_HALT;
      ST_HALT:    if (brk_service) state_d = mode_q ? ST_SETTLE : ST_RELEASE;
      ST_SETTLE:  if (settle_over) state_d = ST_RELEASE;
      ST_RELEASE: if (!ack_seen) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= 1'b0;
      dly_q   <= '0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept_cmd) begin
        mode_q <= stop_en;
        dly_q  <= dly_val;
      end
      if (state_q == ST_IDLE) pend_q <= 1'b0;
      else if (state_q == ST_REQ && brk_evt) pend_q <= 1'b1;
      else if (brk_service) pend_q <= 1'b0;
    end
  end

  assign timer_load = brk_service && mode_q;
  assign timer_val  = dly_q;
  assign susp_req_n = !(state_q == ST_REQ || state_q == ST_HALT ||
                        state_q == ST_SETTLE);
  assign clk_stop   = (state_q == ST_HALT) && mode_q;

  // R5: clock stop only rises after the acknowledge was seen
  a_r5_stop_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_stop) |-> $past(ack_seen));

  // R4: no clock stop in handshake-only suspends
  a_r4_no_stop_light: assert property (@(posedge clk) disable iff (!rst_n)
    clk_stop |-> mode_q);

  // R6: clock stop only while suspend is requested
  a_r6_stop_in_susp: assert property (@(posedge clk) disable iff (!rst_n)
    clk_stop |-> !susp_req_n);

  // R7: in clock-stop mode the release follows an expired delay
  a_r7_release_timed: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(susp_req_n) && mode_q) |-> $past(settle_over));

  // R10: idle is left only through a command
  a_r10_idle_exit: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == ST_IDLE && state_q != ST_IDLE) |-> $past(start_cmd));

  // R9: mode is stable while busy
  a_r9_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && $past(state_q) != ST_IDLE) |-> $stable(mode_q));

endmodule

// File: rtl/susp_seq_top.sv
module susp_seq_top #(
  parameter int REG_W = 8,
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr_en,
  input  logic [REG_W-1:0] cfg_wr_data,
  output logic [REG_W-1:0] cfg_rd_data,
  input  logic             cmd_wr_en,
  input  logic [REG_W-1:0] cmd_wr_data,
  input  logic             ms_tick,
  input  logic             brk_evt,
  input  logic             susp_ack_n,
  output logic             susp_req_n,
  output logic             clk_stop
);
  logic [DLY_W-1:0] dly_val;
  logic             stop_en;
  logic             timer_load;
  logic [DLY_W-1:0] timer_val;
  logic             timer_done;
  logic             start_cmd;

  assign start_cmd = cmd_wr_en && cmd_wr_data[0];

  susp_ctl_reg #(.REG_W(REG_W), .DLY_W(DLY_W)) u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr_en),
    .wr_data (cfg_wr_data),
    .rd_data (cfg_rd_data),
    .dly_val (dly_val),
    .stop_en (stop_en)
  );

  susp_delay_timer #(.DLY_W(DLY_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (timer_load),
    .load_val (timer_val),
    .tick     (ms_tick),
    .done     (timer_done)
  );

  susp_seq_fsm #(.DLY_W(DLY_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_cmd  (start_cmd),
    .stop_en    (stop_en),
    .dly_val    (dly_val),
    .brk_evt    (brk_evt),
    .susp_ack_n (susp_ack_n),
    .timer_done (timer_done),
    .timer_load (timer_load),
    .timer_val  (timer_val),
    .susp_req_n (susp_req_n),
    .clk_stop   (clk_stop)
  );

  // R3: a start command from idle requests suspend next cycle
  a_r3_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start_cmd && susp_req_n && !clk_stop && susp_ack_n) |=> !susp_req_n);

endmodule

// File: tb/test_susp_seq_top.sv
module test_susp_seq_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr_en = 1'b0;
  logic [7:0] cfg_wr_data = 8'h00;
  logic [7:0] cfg_rd_data;
  logic       cmd_wr_en = 1'b0;
  logic [7:0] cmd_wr_data = 8'h00;
  logic       ms_tick = 1'b0;
  logic       brk_evt = 1'b0;
  logic       susp_ack_n = 1'b1;
  logic       susp_req_n;
  logic       clk_stop;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  susp_seq_top i_susp_seq_top (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data), .cfg_rd_data(cfg_rd_data),
    .cmd_wr_en(cmd_wr_en), .cmd_wr_data(cmd_wr_data),
    .ms_tick(ms_tick), .brk_evt(brk_evt),
    .susp_ack_n(susp_ack_n), .susp_req_n(susp_req_n), .clk_stop(clk_stop)
  );

  function automatic logic [7:0] exp_read(input logic [7:0] w);
    return w & 8'hF1;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_out(input logic rq, input logic cs, input string req);
    check(susp_req_n == rq, req, susp_req_n, rq);
    check(clk_stop == cs, req, clk_stop, cs);
  endtask

  task automatic write_ctl(input logic [7:0] v);
    cfg_wr_en = 1'b1; cfg_wr_data = v;
    step();
    cfg_wr_en = 1'b0;
    check(cfg_rd_data == exp_read(v), "R1", cfg_rd_data, exp_read(v));
  endtask

  task automatic run_suspend(input logic mode, input int dly, input int ack_lat,
                             input bit early_brk, input int gap, input bit meddle);
    write_ctl({4'(dly), 3'($urandom_range(0, 7)), mode});
    cmd_wr_en = 1'b1; cmd_wr_data = {7'($urandom), 1'b1};
    step();
    cmd_wr_en = 1'b0;
    expect_out(1'b0, 1'b0, "R3");
    if (meddle) write_ctl({~4'(dly), 3'b000, ~mode});
    for (int i = 0; i < ack_lat; i++) begin
      if (early_brk && i == 0) brk_evt = 1'b1;
      if (i == 1) begin cmd_wr_en = 1'b1; cmd_wr_data = 8'h01; end
      step();
      brk_evt = 1'b0; cmd_wr_en = 1'b0;
      expect_out(1'b0, 1'b0, "R5");
    end
    if (early_brk && ack_lat == 0) begin
      brk_evt = 1'b1;
    end
    susp_ack_n = 1'b0;
    step();
    brk_evt = 1'b0;
    expect_out(1'b0, mode, mode ? "R5" : "R4");
    if (!early_brk) begin
      for (int i = 0; i < 3; i++) begin
        ms_tick = 1'b1;
        step();
        ms_tick = 1'b0;
        expect_out(1'b0, mode, "R9");
      end
      brk_evt = 1'b1;
      step();
      brk_evt = 1'b0;
    end else begin
      step();
    end
    if (!mode) begin
      expect_out(1'b1, 1'b0, early_brk ? "R8" : "R4");
    end else begin
      expect_out(1'b0, 1'b0, early_brk ? "R8" : "R6");
      for (int t = 0; t < dly; t++) begin
        for (int g = 0; g < gap; g++) begin
          step();
          expect_out(1'b0, 1'b0, "R7");
        end
        ms_tick = 1'b1;
        step();
        ms_tick = 1'b0;
        expect_out(1'b0, 1'b0, "R7");
      end
      step();
      expect_out(1'b1, 1'b0, "R7");
    end
    cmd_wr_en = 1'b1; cmd_wr_data = 8'h01;
    step();
    cmd_wr_en = 1'b0;
    expect_out(1'b1, 1'b0, "R9");
    susp_ack_n = 1'b1;
    step();
    expect_out(1'b1, 1'b0, "R10");
    cmd_wr_en = 1'b1; cmd_wr_data = 8'hFE;
    step();
    cmd_wr_en = 1'b0;
    expect_out(1'b1, 1'b0, "R3");
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h1357);
    repeat (3) @(negedge clk);
    check(cfg_rd_data == 8'h00, "R2", cfg_rd_data, 0);
    expect_out(1'b1, 1'b0, "R2");
    rst_n = 1'b1;
    step();
    check(cfg_rd_data == 8'h00, "R2", cfg_rd_data, 0);
    write_ctl(8'hFF);
    write_ctl(8'h0E);
    // directed corners
    run_suspend(1'b1, 0, 0, 1'b0, 0, 1'b0);
    run_suspend(1'b1, 15, 2, 1'b0, 0, 1'b1);
    run_suspend(1'b0, 7, 1, 1'b0, 1, 1'b1);
    run_suspend(1'b1, 3, 0, 1'b1, 2, 1'b0);
    run_suspend(1'b0, 0, 3, 1'b1, 0, 1'b0);
    run_suspend(1'b1, 1, 4, 1'b1, 3, 1'b1);
    for (int n = 0; n < 40; n++) begin
      run_suspend(1'($urandom), $urandom_range(0, 15), $urandom_range(0, 5),
                  1'($urandom), $urandom_range(0, 4), 1'($urandom));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule